// File: doc/BRIEF.md
# Multiplexed Static-Bus to AHB Bridge

This block sits on the slave side of a narrow static-memory-style bus. An external controller drives a chip select, a write strobe, nine upper address lines and a 16-bit bus that carries the address first and the data after. The bridge turns each bus transaction into one full-word AHB-lite transfer on its master port. It waits on the AHB ready signal and holds the controller off with an active-low wait line until the AHB side has finished.

The controller supplies a 25-bit word address. Nine bits arrive on the upper lines and sixteen on the shared bus, both taken on the clock edge where chip select is first seen low. A static 7-bit page input fills the top of the 32-bit AHB address. The level of the write strobe on that same edge chooses read or write. A write collects the low data halfword and then the high one on the next two edges, then issues the AHB write. A read issues the AHB read at once and returns the word on the shared bus as low halfword then high halfword on two consecutive clocks.

Everything runs on one clock with a synchronous active-high reset.

Top module: `msb_ahb_bridge`

## Requirements
- R1: While reset is applied and in the cycle after it, the AHB transfer type is IDLE (2'b00), the wait line is high and the bridge does not drive the shared bus.
- R2: A transaction starts on the first rising edge with chip select low after it was high. The AHB address is {page[6:0], upper lines[8:0], shared bus[15:0]} as sampled on that edge.
- R3: For a write (write strobe low on the start edge), the shared bus is sampled on the next two edges as data bits [15:0] and then [31:16]. Exactly one AHB transfer follows, with transfer type NONSEQ (2'b10), write high, size 3'b010 and write data equal to the assembled word.
- R4: For a write, the wait line stays high during the two data beats. It is low from the cycle after the high-half edge until the AHB data phase completes.
- R5: For a read, the AHB read (NONSEQ, write low, size 3'b010) is presented in the cycle after the start edge. The wait line stays low until the read data has been taken.
- R6: In the first cycle after a read in which the wait line is high, the bridge drives read data bits [15:0] on the shared bus. In the following cycle it drives bits [31:16].
- R7: The shared bus is released whenever chip select is high, and in every cycle other than the two read-data cycles.
- R8: While the AHB address phase is stalled by ready low, the transfer type, address and direction stay unchanged.
- R9: Each bus transaction makes exactly one AHB transfer. Holding chip select low after completion starts no further transfer.
- R10: If chip select rises before both write halfwords have been taken, the write is dropped, no AHB transfer is made and the bridge waits for the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and AHB clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_page | input | 7 | Static upper address bits [31:25] |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_we_n | input | 1 | Active-low write strobe, sampled on the start edge |
| bus_ahi | input | 9 | Upper word address bits [24:16] |
| bus_ad | inout | 16 | Shared address / data bus |
| bus_wait_n | output | 1 | Active-low wait back to the controller |
| m_haddr | output | 32 | AHB address |
| m_htrans | output | 2 | AHB transfer type (IDLE or NONSEQ) |
| m_hwrite | output | 1 | AHB direction, high for write |
| m_hsize | output | 3 | AHB size, always word |
| m_hwdata | output | 32 | AHB write data |
| m_hrdata | input | 32 | AHB read data |
| m_hready | input | 1 | AHB ready |

## Verification
Inputs change on the falling edge, and every output is sampled on a later falling edge, half a cycle after the rising edge that moved it.

The cycle counts after the start edge are as follows:
- A write shows a high wait line on the first and second falling edges and a low one on the third.
- A read shows a low wait line on the first falling edge.
- The low read halfword appears on the first falling edge with the wait line high, and the high halfword one edge after that.
- The bus is released one edge later again.

The bench's AHB model picks ready for the coming edge and predicts there whether the address or data phase will complete. It records the transfer only when that edge is certain. The transfer counts and recorded fields are checked only after the wait line has risen.

// File: rtl/msb_pkg.sv
package msb_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int BUS_AW   = 25;
    localparam int UPPER_W  = BUS_AW - HALF_W;
    localparam int PAGE_W   = WORD_W - BUS_AW;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [2:0] HS_WORD   = 3'b010;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WR_LO,
        PH_WR_HI,
        PH_WR_ADR,
        PH_WR_DAT,
        PH_RD_ADR,
        PH_RD_DAT,
        PH_RD_LO,
        PH_RD_HI,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic              is_wr;
        logic [BUS_AW-1:0] waddr;
    } xfer_t;

    function automatic logic [WORD_W-1:0] join_addr(
        input logic [PAGE_W-1:0] page,
        input logic [BUS_AW-1:0] waddr
    );
        return {page, waddr};
    endfunction

    function automatic logic holds_off(input phase_e ph);
        return (ph == PH_WR_ADR) || (ph == PH_WR_DAT) ||
               (ph == PH_RD_ADR) || (ph == PH_RD_DAT);
    endfunction

    function automatic logic on_ahb_addr(input phase_e ph);
        return (ph == PH_WR_ADR) || (ph == PH_RD_ADR);
    endfunction

endpackage

// File: rtl/msb_seq.sv
module msb_seq
    import msb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   we_n,
    input  logic   hready,
    output phase_e phase,
    output logic   start,
    output logic   lo_take,
    output logic   hi_take,
    output logic   rd_take
);

    phase_e phase_nx;

    assign start   = (phase == PH_IDLE)   && !cs_n;
    assign lo_take = (phase == PH_WR_LO)  && !cs_n;
    assign hi_take = (phase == PH_WR_HI)  && !cs_n;
    assign rd_take = (phase == PH_RD_DAT) && hready;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:   if (!cs_n) phase_nx = we_n ? PH_RD_ADR : PH_WR_LO;
            PH_WR_LO:  phase_nx = cs_n ? PH_IDLE : PH_WR_HI;
            PH_WR_HI:  phase_nx = cs_n ? PH_IDLE : PH_WR_ADR;
            PH_WR_ADR: if (hready) phase_nx = PH_WR_DAT;
            PH_WR_DAT: if (hready) phase_nx = PH_HOLD;
            PH_RD_ADR: if (hready) phase_nx = PH_RD_DAT;
            PH_RD_DAT: if (hready) phase_nx = PH_RD_LO;
            PH_RD_LO:  phase_nx = cs_n ? PH_HOLD : PH_RD_HI;
            PH_RD_HI:  phase_nx = PH_HOLD;
            PH_HOLD:   if (cs_n) phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end

endmodule

// File: rtl/msb_word_buf.sv
module msb_word_buf
    import msb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               we_n,
    input  phase_e             phase,
    input  logic               start,
    input  logic               lo_take,
    input  logic               hi_take,
    input  logic               rd_take,
    input  logic [UPPER_W-1:0] upper,
    input  logic [HALF_W-1:0]  ad_in,
    input  logic [WORD_W-1:0]  hrdata,
    output xfer_t              xfer,
    output logic [WORD_W-1:0]  wword,
    output logic               drv_en,
    output logic [HALF_W-1:0]  drv_val
);

    logic [HALF_W-1:0] half_q [2];
    logic [WORD_W-1:0] rword;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer <= '0;
        end else if (start) begin
            xfer.is_wr <= !we_n;
            xfer.waddr <= {upper, ad_in};
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic take;
        assign take = (g == 0) ? lo_take : hi_take;
        always_ff @(posedge clk) begin
            if (rst)       half_q[g] <= '0;
            else if (take) half_q[g] <= ad_in;
        end
    end

    assign wword = {half_q[1], half_q[0]};

    always_ff @(posedge clk) begin
        if (rst)          rword <= '0;
        else if (rd_take) rword <= hrdata;
    end

    assign drv_en  = !cs_n && ((phase == PH_RD_LO) || (phase == PH_RD_HI));
    assign drv_val = (phase == PH_RD_HI) ? rword[WORD_W-1:HALF_W] : rword[HALF_W-1:0];

endmodule

// File: rtl/msb_ahb_drv.sv
module msb_ahb_drv
    import msb_pkg::*;
(
    input  phase_e             phase,
    input  xfer_t              xfer,
    input  logic [PAGE_W-1:0]  page,
    input  logic [WORD_W-1:0]  wword,
    output logic [WORD_W-1:0]  haddr,
    output logic [1:0]         htrans,
    output logic               hwrite,
    output logic [2:0]         hsize,
    output logic [WORD_W-1:0]  hwdata
);

    assign htrans = on_ahb_addr(phase) ? HT_NONSEQ : HT_IDLE;
    assign haddr  = join_addr(page, xfer.waddr);
    assign hwrite = xfer.is_wr;
    assign hsize  = HS_WORD;
    assign hwdata = wword;

endmodule

// File: rtl/msb_ahb_bridge.sv
module msb_ahb_bridge
    import msb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PAGE_W-1:0]  cfg_page,
    input  logic               bus_cs_n,
    input  logic               bus_we_n,
    input  logic [UPPER_W-1:0] bus_ahi,
    inout  wire  [HALF_W-1:0]  bus_ad,
    output logic               bus_wait_n,
    output logic [WORD_W-1:0]  m_haddr,
    output logic [1:0]         m_htrans,
    output logic               m_hwrite,
    output logic [2:0]         m_hsize,
    output logic [WORD_W-1:0]  m_hwdata,
    input  logic [WORD_W-1:0]  m_hrdata,
    input  logic               m_hready
);

    phase_e             phase;
    logic               start, lo_take, hi_take, rd_take;
    xfer_t              xfer;
    logic [WORD_W-1:0]  wword;
    logic               drv_en;
    logic [HALF_W-1:0]  drv_val;
    logic [HALF_W-1:0]  ad_in;

    assign ad_in  = bus_ad;
    assign bus_ad = drv_en ? drv_val : {HALF_W{1'bz}};
    assign bus_wait_n = !holds_off(phase);

    msb_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (bus_cs_n),
        .we_n    (bus_we_n),
        .hready  (m_hready),
        .phase   (phase),
        .start   (start),
        .lo_take (lo_take),
        .hi_take (hi_take),
        .rd_take (rd_take)
    );

    msb_word_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (bus_cs_n),
        .we_n    (bus_we_n),
        .phase   (phase),
        .start   (start),
        .lo_take (lo_take),
        .hi_take (hi_take),
        .rd_take (rd_take),
        .upper   (bus_ahi),
        .ad_in   (ad_in),
        .hrdata  (m_hrdata),
        .xfer    (xfer),
        .wword   (wword),
        .drv_en  (drv_en),
        .drv_val (drv_val)
    );

    msb_ahb_drv u_drv (
        .phase  (phase),
        .xfer   (xfer),
        .page   (cfg_page),
        .wword  (wword),
        .haddr  (m_haddr),
        .htrans (m_htrans),
        .hwrite (m_hwrite),
        .hsize  (m_hsize),
        .hwdata (m_hwdata)
    );

endmodule

// File: rtl/msb_ahb_bridge_chk.sv
module msb_ahb_bridge_chk
    import msb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [PAGE_W-1:0]  cfg_page,
    input logic               bus_cs_n,
    input logic               bus_wait_n,
    input logic               drv_en,
    input logic [WORD_W-1:0]  m_haddr,
    input logic [1:0]         m_htrans,
    input logic               m_hwrite,
    input logic [2:0]         m_hsize,
    input logic               m_hready
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (m_htrans == HT_IDLE && bus_wait_n && !drv_en)); // R1

    AST_PAGE_ON_TOP: assert property (@(posedge clk) disable iff (rst) (m_htrans == HT_NONSEQ) |-> (m_haddr[WORD_W-1:BUS_AW] == cfg_page)); // R2

    AST_WORD_SIZE: assert property (@(posedge clk) disable iff (rst) (m_htrans != HT_IDLE) |-> (m_hsize == HS_WORD)); // R3

    AST_WAIT_IN_ADDR: assert property (@(posedge clk) disable iff (rst) (m_htrans == HT_NONSEQ) |-> !bus_wait_n); // R4

    AST_DRIVE_NOT_WAITING: assert property (@(posedge clk) disable iff (rst) drv_en |-> bus_wait_n); // R6

    AST_RELEASE_CS_HIGH: assert property (@(posedge clk) disable iff (rst) bus_cs_n |-> !drv_en); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) (m_htrans == HT_NONSEQ && !m_hready) |=> (m_htrans == HT_NONSEQ && $stable(m_haddr) && $stable(m_hwrite))); // R8

    AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (rst) (m_htrans == HT_NONSEQ && m_hready) |=> (m_htrans == HT_IDLE)); // R9

endmodule

bind msb_ahb_bridge msb_ahb_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_page   (cfg_page),
    .bus_cs_n   (bus_cs_n),
    .bus_wait_n (bus_wait_n),
    .drv_en     (drv_en),
    .m_haddr    (m_haddr),
    .m_htrans   (m_htrans),
    .m_hwrite   (m_hwrite),
    .m_hsize    (m_hsize),
    .m_hready   (m_hready)
);

// File: tb/msb_ahb_bridge_bench.sv
module msb_ahb_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cfg_page = 7'h5A;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic [8:0]  ahi = '0;
    logic [15:0] tb_ad = '0;
    logic        tb_drv = 1'b1;
    wire  [15:0] bus_ad;
    logic        wait_n;
    logic [31:0] haddr, hwdata;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [31:0] hrdata = '0;
    logic        hready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    // AHB slave model state
    int          xfers = 0;
    logic        dp = 1'b0;
    logic [31:0] got_addr = '0, got_wdata = '0;
    logic        got_wr = 1'b0;
    logic [2:0]  got_size = '0;
    logic [31:0] rd_word = '0;
    int          stall_pct = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;

    always #5 clk = ~clk;

    assign bus_ad = tb_drv ? tb_ad : 16'bz;

    msb_ahb_bridge u_msb_ahb_bridge (
        .clk        (clk),
        .rst        (rst),
        .cfg_page   (cfg_page),
        .bus_cs_n   (cs_n),
        .bus_we_n   (we_n),
        .bus_ahi    (ahi),
        .bus_ad     (bus_ad),
        .bus_wait_n (wait_n),
        .m_haddr    (haddr),
        .m_htrans   (htrans),
        .m_hwrite   (hwrite),
        .m_hsize    (hsize),
        .m_hwdata   (hwdata),
        .m_hrdata   (hrdata),
        .m_hready   (hready)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic slave_step();
        if (prev_stall)
            check(htrans == 2'b10 && haddr == prev_addr, "R8", "stalled address phase moved", haddr, prev_addr);
        hready = ($urandom_range(99) >= stall_pct);
        hrdata = rd_word;
        if (dp && hready) begin
            if (got_wr) got_wdata = hwdata;
            dp = 1'b0;
        end
        if (htrans == 2'b10 && hready) begin
            xfers++;
            got_addr = haddr;
            got_wr   = hwrite;
            got_size = hsize;
            dp       = 1'b1;
        end
        prev_stall = (htrans == 2'b10) && !hready;
        prev_addr  = haddr;
    endtask

    task automatic tick();
        @(negedge clk);
        slave_step();
    endtask

    task automatic wait_release();
        int n = 0;
        while (!wait_n && n < 2000) begin
            tick();
            n++;
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [24:0] a);
        return {cfg_page, a};
    endfunction

    task automatic do_write(input logic [24:0] a, input logic [31:0] d);
        int x0 = xfers;
        tick();
        cs_n = 1'b0; we_n = 1'b0; ahi = a[24:16]; tb_drv = 1'b1; tb_ad = a[15:0];
        tick();
        check(wait_n == 1'b1, "R4", "wait during low beat", {31'b0, wait_n}, 32'd1);
        tb_ad = d[15:0];
        tick();
        check(wait_n == 1'b1, "R4", "wait during high beat", {31'b0, wait_n}, 32'd1);
        tb_ad = d[31:16];
        tick();
        check(wait_n == 1'b0, "R4", "wait after data beats", {31'b0, wait_n}, 32'd0);
        tb_ad = 16'($urandom);
        wait_release();
        check(xfers == x0 + 1, "R9", "write transfer count", 32'(xfers - x0), 32'd1);
        check(got_addr == exp_addr(a), "R2", "write address", got_addr, exp_addr(a));
        check(got_wr == 1'b1 && got_size == 3'b010, "R3", "write dir/size", {28'b0, got_wr, got_size}, {28'b0, 4'b1010});
        check(got_wdata == d, "R3", "write data", got_wdata, d);
        tick();
        check(xfers == x0 + 1, "R9", "no extra transfer with cs low", 32'(xfers - x0), 32'd1);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic do_read(input logic [24:0] a, input logic [31:0] d);
        int x0 = xfers;
        rd_word = d;
        tick();
        cs_n = 1'b0; we_n = 1'b1; ahi = a[24:16]; tb_drv = 1'b1; tb_ad = a[15:0];
        tick();
        check(wait_n == 1'b0, "R5", "wait after read start", {31'b0, wait_n}, 32'd0);
        check(bus_ad == a[15:0], "R7", "bus released during read wait", {16'b0, bus_ad}, {16'b0, a[15:0]});
        tb_drv = 1'b0;
        wait_release();
        check(xfers == x0 + 1, "R9", "read transfer count", 32'(xfers - x0), 32'd1);
        check(got_addr == exp_addr(a), "R2", "read address", got_addr, exp_addr(a));
        check(got_wr == 1'b0 && got_size == 3'b010, "R5", "read dir/size", {28'b0, got_wr, got_size}, {28'b0, 4'b0010});
        check(bus_ad == d[15:0], "R6", "low read halfword", {16'b0, bus_ad}, {16'b0, d[15:0]});
        tick();
        check(bus_ad == d[31:16], "R6", "high read halfword", {16'b0, bus_ad}, {16'b0, d[31:16]});
        tb_drv = 1'b1; tb_ad = 16'h0000;
        tick();
        check(bus_ad == 16'h0000, "R7", "bus released after read", {16'b0, bus_ad}, 32'd0);
        check(xfers == x0 + 1, "R9", "no extra read transfer", 32'(xfers - x0), 32'd1);
        cs_n = 1'b1;
    endtask

    task automatic do_cancel(input logic [24:0] a, input int beats);
        int x0 = xfers;
        tick();
        cs_n = 1'b0; we_n = 1'b0; ahi = a[24:16]; tb_drv = 1'b1; tb_ad = a[15:0];
        for (int i = 0; i < beats; i++) begin
            tick();
            tb_ad = 16'($urandom);
        end
        cs_n = 1'b1; we_n = 1'b1;
        repeat (4) tick();
        check(xfers == x0, "R10", "dropped write made transfer", 32'(xfers - x0), 32'd0);
        check(wait_n == 1'b1, "R10", "wait after dropped write", {31'b0, wait_n}, 32'd1);
        check(bus_ad == tb_ad, "R7", "bus released with cs high", {16'b0, bus_ad}, {16'b0, tb_ad});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        tb_drv = 1'b1; tb_ad = 16'h0000;
        repeat (3) tick();
        check(wait_n == 1'b1, "R1", "wait in reset", {31'b0, wait_n}, 32'd1);
        check(htrans == 2'b00, "R1", "htrans in reset", {30'b0, htrans}, 32'd0);
        check(bus_ad == 16'h0000, "R1", "bus driven in reset", {16'b0, bus_ad}, 32'd0);
        rst = 1'b0;
        tick();
        check(htrans == 2'b00 && wait_n, "R1", "idle after reset", {30'b0, htrans}, 32'd0);

        // directed corners
        stall_pct = 0;
        do_write(25'h1FF_FFFF, 32'hDEAD_BEEF);
        do_read(25'h000_0000, 32'h1234_8765);
        cfg_page = 7'h7F;
        stall_pct = 80;
        do_write(25'h000_0000, 32'hFFFF_0000);
        do_read(25'h1FF_FFFF, 32'h0001_FFFF);
        cfg_page = 7'h00;
        do_cancel(25'h0AB_CDEF, 1);
        do_cancel(25'h155_5555, 2);
        do_read(25'h0F0_F0F0, 32'hA5A5_5A5A);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [24:0] a;
            logic [31:0] d;
            a = 25'($urandom);
            d = $urandom | 32'h0001_0000;
            stall_pct = $urandom_range(70);
            if (i % 8 == 7) cfg_page = 7'($urandom);
            case ($urandom_range(9))
                0:       do_cancel(a, $urandom_range(2));
                1,2,3,4: do_write(a, d);
                default: do_read(a, d);
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule